// File: doc/BRIEF.md
# Endian-Selectable Long-Word to Narrow-Lane Bus Matcher

This block joins a 36-bit long-word stream to a narrow stream whose lane width is either a 9-bit byte or an 18-bit half word. It has two independent paths. The splitting path takes one long word and hands it out as a series of narrow pieces. The merging path gathers a series of narrow pieces and presents them as one long word. Both paths share one clock and one active-low reset.

Two plain configuration pins set the piece order (big or little endian) and the lane width (byte or half word). The block samples them on every clock edge while reset is held low. The value from the last edge before release stays in force until the next reset. Every data interface uses valid/ready. A transfer happens on a rising edge where both are high. A source that has raised valid keeps valid high and its data unchanged until ready is seen. The block holds its own output valids and data stable while the consumer holds ready low. Back-pressure from the narrow consumer stalls the splitter's long-word input. Back-pressure from the long-word consumer stalls the merger's narrow input.

Top module: `bus_matcher_top`

## Requirements
- R1: The endian and lane-width selections are taken from the pins at the last clock edge before reset is released. Pin changes after release have no effect until the next reset.
- R2: With big endian selected, the splitter outputs the most significant piece of the long word first and the least significant piece last.
- R3: With little endian selected, the splitter outputs the least significant piece first and the most significant piece last.
- R4: With big endian selected, the merger places the first narrow piece it receives in the most significant position and the last piece in the least significant position.
- R5: With little endian selected, the merger places the first piece in the least significant position and the last piece in the most significant position.
- R6: In byte mode (width pin high), a long word is four 9-bit pieces, where piece k is bits [9k+8:9k]. Narrow output bits [17:9] read zero, and narrow input bits [17:9] are ignored.
- R7: In half-word mode (width pin low), a long word is two 18-bit pieces: bits [17:0] and bits [35:18].
- R8: While any piece of the current long word remains untaken, the splitter's long-word ready is low. It returns high in the cycle after the last piece is taken.
- R9: The merger raises its long-word valid only after the final piece is received. While that long word waits to be taken, the merger's narrow ready is low.
- R10: While an output valid is high and its ready is low, that valid stays high and its data stays unchanged.
- R11: Reset drops any partly split or partly merged word. After reset both output valids are low, both input readies are high, and the piece count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cfg_big_endian | input | 1 | 1 = big-endian piece order; sampled while reset is low |
| cfg_byte_lanes | input | 1 | 1 = 9-bit lanes, 0 = 18-bit lanes; sampled while reset is low |
| wide_in_valid | input | 1 | Long word offered to the splitter |
| wide_in_ready | output | 1 | Splitter can take a long word |
| wide_in_data | input | 36 | Long word to split |
| nar_out_valid | output | 1 | Narrow piece available from the splitter |
| nar_out_ready | input | 1 | Consumer takes the narrow piece |
| nar_out_data | output | 18 | Narrow piece, zero-extended in byte mode |
| nar_in_valid | input | 1 | Narrow piece offered to the merger |
| nar_in_ready | output | 1 | Merger can take a narrow piece |
| nar_in_data | input | 18 | Narrow piece; only [8:0] used in byte mode |
| wide_out_valid | output | 1 | Merged long word available |
| wide_out_ready | input | 1 | Consumer takes the merged long word |
| wide_out_data | output | 36 | Merged long word |

## Verification
The assertions are checked on every cycle. They cover these rules: the latched configuration never moves between resets, each side blocks its input while its output is pending, stalled outputs hold, and byte-mode output keeps its upper lane bits at zero. Only the bench scenarios can show piece ordering and placement. They run known long words and piece sequences through each path in all four endian and width combinations. They also show that configuration pins changed after reset are ignored, and that a reset in mid-word drops the partial state.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int LANES_MAX = 4;
  localparam int CNT_W     = $clog2(LANES_MAX);

  typedef struct packed {
    logic big_endian;
    logic byte_lanes;
  } bm_cfg_t;

  // Position of the piece handled at transfer number k.
  function automatic logic [CNT_W-1:0] lane_pos(bm_cfg_t c, logic [CNT_W-1:0] k);
    logic [CNT_W-1:0] last;
    last = c.byte_lanes ? CNT_W'(LANES_MAX - 1) : CNT_W'(LANES_MAX / 2 - 1);
    return c.big_endian ? CNT_W'(last - k) : k;
  endfunction

  function automatic logic [CNT_W-1:0] last_count(bm_cfg_t c);
    return c.byte_lanes ? CNT_W'(LANES_MAX - 1) : CNT_W'(LANES_MAX / 2 - 1);
  endfunction
endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
  import bm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_big_endian,
  input  logic    pin_byte_lanes,
  output bm_cfg_t cfg
);
  // Track the pins while reset is low and freeze on release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.big_endian <= pin_big_endian;
      cfg.byte_lanes <= pin_byte_lanes;
    end
  end
endmodule

// File: rtl/bm_unpacker.sv
module bm_unpacker
  import bm_pkg::*;
#(
  parameter int WIDE_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bm_cfg_t             cfg,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WIDE_W-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WIDE_W/2-1:0] out_data
);
  localparam int BYTE_W = WIDE_W / LANES_MAX;
  localparam int HALF_W = WIDE_W / 2;

  logic [WIDE_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [CNT_W-1:0]  pos;
  logic [BYTE_W-1:0] byte_sel;

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign pos       = lane_pos(cfg, cnt_q);

  always_comb begin
    byte_sel = '0;
    for (int i = 0; i < LANES_MAX; i++) begin
      if (pos == CNT_W'(i)) byte_sel = hold_q[i*BYTE_W +: BYTE_W];
    end
    if (cfg.byte_lanes) begin
      out_data = '0;
      out_data[BYTE_W-1:0] = byte_sel;
    end else begin
      out_data = pos[0] ? hold_q[WIDE_W-1:HALF_W] : hold_q[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (in_valid) begin
        hold_q <= in_data;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (out_ready) begin
      if (cnt_q == last_count(cfg)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bm_packer.sv
module bm_packer
  import bm_pkg::*;
#(
  parameter int WIDE_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bm_cfg_t             cfg,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WIDE_W/2-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WIDE_W-1:0]   out_data
);
  localparam int BYTE_W = WIDE_W / LANES_MAX;
  localparam int HALF_W = WIDE_W / 2;

  logic [WIDE_W-1:0] acc_q;
  logic [WIDE_W-1:0] acc_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic [CNT_W-1:0]  pos;

  assign in_ready  = !done_q;
  assign out_valid = done_q;
  assign out_data  = acc_q;
  assign pos       = lane_pos(cfg, cnt_q);

  always_comb begin
    acc_next = acc_q;
    if (cfg.byte_lanes) begin
      for (int i = 0; i < LANES_MAX; i++) begin
        if (pos == CNT_W'(i)) acc_next[i*BYTE_W +: BYTE_W] = in_data[BYTE_W-1:0];
      end
    end else if (pos[0]) begin
      acc_next[WIDE_W-1:HALF_W] = in_data;
    end else begin
      acc_next[HALF_W-1:0] = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (done_q) begin
      if (out_ready) done_q <= 1'b0;
    end else if (in_valid) begin
      acc_q <= acc_next;
      if (cnt_q == last_count(cfg)) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_matcher_top.sv
module bus_matcher_top
  import bm_pkg::*;
#(
  parameter int WIDE_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_big_endian,
  input  logic                cfg_byte_lanes,
  input  logic                wide_in_valid,
  output logic                wide_in_ready,
  input  logic [WIDE_W-1:0]   wide_in_data,
  output logic                nar_out_valid,
  input  logic                nar_out_ready,
  output logic [WIDE_W/2-1:0] nar_out_data,
  input  logic                nar_in_valid,
  output logic                nar_in_ready,
  input  logic [WIDE_W/2-1:0] nar_in_data,
  output logic                wide_out_valid,
  input  logic                wide_out_ready,
  output logic [WIDE_W-1:0]   wide_out_data
);
  bm_cfg_t cfg_q;

  bm_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n),
    .pin_big_endian(cfg_big_endian), .pin_byte_lanes(cfg_byte_lanes),
    .cfg(cfg_q)
  );

  bm_unpacker #(.WIDE_W(WIDE_W)) u_split (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .in_valid(wide_in_valid), .in_ready(wide_in_ready), .in_data(wide_in_data),
    .out_valid(nar_out_valid), .out_ready(nar_out_ready), .out_data(nar_out_data)
  );

  bm_packer #(.WIDE_W(WIDE_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .in_valid(nar_in_valid), .in_ready(nar_in_ready), .in_data(nar_in_data),
    .out_valid(wide_out_valid), .out_ready(wide_out_ready), .out_data(wide_out_data)
  );
endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
  parameter int WIDE_W = 36
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_be,
  input logic                cfg_byte,
  input logic                wide_in_ready,
  input logic                nar_out_valid,
  input logic                nar_out_ready,
  input logic [WIDE_W/2-1:0] nar_out_data,
  input logic                nar_in_ready,
  input logic                wide_out_valid,
  input logic                wide_out_ready,
  input logic [WIDE_W-1:0]   wide_out_data
);
  localparam int BYTE_W = WIDE_W / 4;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(cfg_be) && $stable(cfg_byte))); // R1

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_out_valid && cfg_byte) |-> (nar_out_data[WIDE_W/2-1:BYTE_W] == '0)); // R6

  AST_SPLIT_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    nar_out_valid |-> !wide_in_ready); // R8

  AST_MERGE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    wide_out_valid |-> !nar_in_ready); // R9

  AST_NAR_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_out_valid && !nar_out_ready) |=> (nar_out_valid && $stable(nar_out_data))); // R10

  AST_WIDE_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_out_valid && !wide_out_ready) |=> (wide_out_valid && $stable(wide_out_data))); // R10
endmodule

bind bus_matcher_top bm_checker #(.WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_be(cfg_q.big_endian), .cfg_byte(cfg_q.byte_lanes),
  .wide_in_ready(wide_in_ready),
  .nar_out_valid(nar_out_valid), .nar_out_ready(nar_out_ready), .nar_out_data(nar_out_data),
  .nar_in_ready(nar_in_ready),
  .wide_out_valid(wide_out_valid), .wide_out_ready(wide_out_ready), .wide_out_data(wide_out_data)
);

// File: tb/tb_bus_matcher_top.sv
module tb_bus_matcher_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        cfg_byte_lanes = 1'b0;
  logic        wide_in_valid = 1'b0;
  logic        wide_in_ready;
  logic [35:0] wide_in_data = '0;
  logic        nar_out_valid;
  logic        nar_out_ready = 1'b0;
  logic [17:0] nar_out_data;
  logic        nar_in_valid = 1'b0;
  logic        nar_in_ready;
  logic [17:0] nar_in_data = '0;
  logic        wide_out_valid;
  logic        wide_out_ready = 1'b0;
  logic [35:0] wide_out_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_matcher_top dut (.*);

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Piece k of long word w under the given order and width (R2, R3, R6, R7).
  function automatic logic [17:0] piece(logic [35:0] w, logic be, logic bytes, int k);
    int n = bytes ? 4 : 2;
    int p = be ? n - 1 - k : k;
    if (bytes) return {9'b0, w[p*9 +: 9]};
    return w[p*18 +: 18];
  endfunction

  task automatic do_reset(logic be, logic bytes);
    @(negedge clk);
    rst_n = 1'b0; cfg_big_endian = be; cfg_byte_lanes = bytes;
    wide_in_valid = 0; nar_out_ready = 0; nar_in_valid = 0; wide_out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push_wide(logic [35:0] w);
    @(negedge clk);
    wide_in_valid = 1'b1; wide_in_data = w;
    while (!wide_in_ready) @(negedge clk);
    @(negedge clk);
    wide_in_valid = 1'b0;
  endtask

  task automatic pull_piece(string req, logic [17:0] exp);
    @(negedge clk);
    nar_out_ready = 1'b1;
    #1;
    chk({req, " valid"}, 36'(nar_out_valid), 36'd1);
    chk({req, " data"}, 36'(nar_out_data), 36'(exp));
    @(negedge clk);
    nar_out_ready = 1'b0;
  endtask

  task automatic push_nar(logic [17:0] d);
    @(negedge clk);
    nar_in_valid = 1'b1; nar_in_data = d;
    while (!nar_in_ready) @(negedge clk);
    @(negedge clk);
    nar_in_valid = 1'b0;
  endtask

  task automatic take_wide(string req, logic [35:0] exp);
    @(negedge clk);
    wide_out_ready = 1'b1;
    #1;
    chk({req, " valid"}, 36'(wide_out_valid), 36'd1);
    chk({req, " data"}, wide_out_data, exp);
    @(negedge clk);
    wide_out_ready = 1'b0;
  endtask

  task automatic split_case(string req, logic be, logic bytes, logic [35:0] w);
    int n = bytes ? 4 : 2;
    do_reset(be, bytes);
    push_wide(w);
    #1 chk({req, " R8 ready low while busy"}, 36'(wide_in_ready), 36'd0);
    for (int k = 0; k < n; k++) pull_piece(req, piece(w, be, bytes, k));
    #1 chk({req, " R8 ready back"}, 36'(wide_in_ready), 36'd1);
  endtask

  task automatic merge_case(string req, logic be, logic bytes, logic [35:0] w);
    int n = bytes ? 4 : 2;
    do_reset(be, bytes);
    for (int k = 0; k < n; k++) begin
      // Byte mode: junk in upper lane bits must be ignored (R6).
      push_nar(piece(w, be, bytes, k) | (bytes ? 18'h3FE00 : 18'h0));
      if (k < n - 1) begin
        #1 chk({req, " R9 no early valid"}, 36'(wide_out_valid), 36'd0);
      end
    end
    #1 chk({req, " R9 input blocked"}, 36'(nar_in_ready), 36'd0);
    take_wide(req, w);
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b0);
    #1;
    chk("R11 wide_in_ready", 36'(wide_in_ready), 36'd1);
    chk("R11 nar_in_ready", 36'(nar_in_ready), 36'd1);
    chk("R11 nar_out_valid", 36'(nar_out_valid), 36'd0);
    chk("R11 wide_out_valid", 36'(wide_out_valid), 36'd0);
  endtask

  task automatic t_stall();
    logic [35:0] w = 36'hA5C3_96E1_7;
    do_reset(1'b1, 1'b0);
    push_wide(w);
    repeat (3) begin
      @(negedge clk);
      chk("R10 split valid held", 36'(nar_out_valid), 36'd1);
      chk("R10 split data held", 36'(nar_out_data), 36'(piece(w, 1'b1, 1'b0, 0)));
    end
    pull_piece("R10 after stall", piece(w, 1'b1, 1'b0, 0));
    pull_piece("R10 after stall", piece(w, 1'b1, 1'b0, 1));
    push_nar(18'h2_AAAA); push_nar(18'h1_5555);
    repeat (3) begin
      @(negedge clk);
      chk("R10 merge data held", wide_out_data, {18'h2_AAAA, 18'h1_5555});
    end
    take_wide("R10 merge after stall", {18'h2_AAAA, 18'h1_5555});
  endtask

  task automatic t_cfg_frozen();
    logic [35:0] w = 36'h1_2345_6789;
    do_reset(1'b1, 1'b1);
    @(negedge clk);
    cfg_big_endian = 1'b0; cfg_byte_lanes = 1'b0;
    push_wide(w);
    for (int k = 0; k < 4; k++) pull_piece("R1 frozen cfg", piece(w, 1'b1, 1'b1, k));
  endtask

  task automatic t_mid_reset();
    do_reset(1'b0, 1'b1);
    push_nar(18'h0_0011); push_nar(18'h0_0022);
    do_reset(1'b0, 1'b1);
    push_nar(18'h0_01AA); push_nar(18'h0_01BB); push_nar(18'h0_01CC); push_nar(18'h0_01DD);
    take_wide("R11 partial merge dropped", {9'h1DD, 9'h1CC, 9'h1BB, 9'h1AA});
    push_wide(36'hF_0F0F_0F0F);
    pull_piece("R11 split before reset", 18'h0_010F);
    do_reset(1'b0, 1'b1);
    #1;
    chk("R11 split cleared valid", 36'(nar_out_valid), 36'd0);
    chk("R11 split cleared ready", 36'(wide_in_ready), 36'd1);
  endtask

  initial begin
    t_reset_state();
    split_case("R2 R6 split be byte", 1'b1, 1'b1, 36'h9_8765_4321);
    split_case("R3 R6 split le byte", 1'b0, 1'b1, 36'h9_8765_4321);
    split_case("R2 R7 split be word", 1'b1, 1'b0, 36'hC_AFE1_2345);
    split_case("R3 R7 split le word", 1'b0, 1'b0, 36'hC_AFE1_2345);
    merge_case("R4 R6 merge be byte", 1'b1, 1'b1, 36'h3_1415_9265);
    merge_case("R5 R6 merge le byte", 1'b0, 1'b1, 36'h3_1415_9265);
    merge_case("R4 R7 merge be word", 1'b1, 1'b0, 36'hD_EADB_EEF1);
    merge_case("R5 R7 merge le word", 1'b0, 1'b0, 36'hD_EADB_EEF1);
    t_stall();
    t_cfg_frozen();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule